// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a simple processor core and carries out the hardware part of taking an interrupt and returning from it. At each instruction boundary the core raises a one-cycle strobe. The sequencer then looks at four requests: a non-maskable line, a maskable line, a software trap that carries its own 8-bit vector, and a return-from-handler request. If one of them is accepted, the sequencer raises `busy` so the core stalls. For an entry, it pushes the status flags and then the resume address onto a downward-growing stack through a single memory port. It then fetches the handler address from a vector table and presents it with a one-cycle load strobe. A return pops both values back.

The table starts at byte address 0 and holds one 4-byte handler address per vector, so vector `v` is fetched from byte address `v*4`. A maskable request obtains its vector from an external controller. For this the sequencer runs a one-cycle acknowledge, and the controller places the vector on `irq_vec_in` during that cycle. The memory port uses byte addresses. It has a fixed read latency of one cycle: read data is valid in the cycle after the read request.

Top module: `irq_entry_seq`

## Requirements
- R1: The sequencer starts nothing unless `instr_done` is high while it is idle. Requests that are present with no strobe are not acted on. While idle, `mem_req` stays low.
- R2: On entry, the flags are written first, zero-extended, to byte address SP-4. The resume address `pc_next` is written next to SP-8. `sp_out` then ends 8 lower than before entry. `sp_out` resets to `SP_INIT` (0x800).
- R3: The handler address is read from byte address `vector*4`. The word read is presented on `pc_out` for the one cycle in which `pc_load` is high.
- R4: A non-maskable request always enters through vector 2, whatever the value of the interrupt-enable flag. It runs no acknowledge cycle.
- R5: A maskable request is ignored while the interrupt-enable flag `flags_in[IE_BIT]` (bit 9) is 0. In that case no acknowledge is given and `busy` stays low.
- R6: When several requests are present at one boundary, the order of priority is non-maskable, then enabled maskable, then software trap, then return. Only the highest one is taken.
- R7: A software trap uses `swi_vec` as its vector. A maskable entry raises `irq_ack` for exactly one cycle and takes its vector from `irq_vec_in` in that cycle.
- R8: At the end of an entry, `flags_out` is loaded with the saved flags with bit `IE_BIT` cleared, and `flags_load` is high in the same cycle. A maskable request that then arrives with those flags is ignored.
- R9: A return reads the resume address from SP and then the flags from SP+4. It presents them on `pc_out` and `flags_out`, with `pc_load` and `flags_load` high, and `sp_out` ends 8 higher.
- R10: `busy` is high from the cycle after the strobe through the cycle with `pc_load`, and low after that. The count of busy cycles is 5 for a non-maskable or software entry, 6 for a maskable entry and 4 for a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | One-cycle instruction-boundary strobe |
| pc_next | input | AW | Address of the next instruction |
| flags_in | input | FW | Current status flags |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | 1 | Maskable request |
| swi_req | input | 1 | Software trap request |
| swi_vec | input | 8 | Vector of the software trap |
| iret_req | input | 1 | Return-from-handler request |
| irq_ack | output | 1 | Acknowledge cycle to the external controller |
| irq_vec_in | input | 8 | Vector from the controller during acknowledge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data, one cycle after the request |
| busy | output | 1 | Core stall |
| pc_load | output | 1 | Load strobe for the program counter |
| pc_out | output | AW | New program counter value |
| flags_load | output | 1 | Load strobe for the flags |
| flags_out | output | FW | New flags value |
| sp_out | output | AW | Current stack pointer |

## Verification
The bench goes after priority collisions: non-maskable with maskable, maskable with software, and software with return. A design that arbitrated in the wrong order would fetch the wrong table entry, or would run an acknowledge cycle where none belongs. It checks a masked request and a request issued right after entry with the enable bit cleared; a design that ignored the mask would start a sequence and raise `busy`. It checks vectors 0 and 255 and the stack contents and order, which catch a wrong table stride, swapped push order or a mis-stepped stack pointer. It checks the exact busy length of each path, so an extra or missing state shows up as a latency error.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACK,
    S_PUSH_F,
    S_PUSH_PC,
    S_RD_VEC,
    S_WAIT_V,
    S_POP_PC,
    S_POP_F,
    S_WAIT_F,
    S_LOAD
  } seq_state_t;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_NMI,
    EV_IRQ,
    EV_SWI,
    EV_RET
  } seq_event_t;

  localparam logic [7:0] NMI_VECTOR = 8'd2;

endpackage

// File: rtl/irq_event_arb.sv
module irq_event_arb
  import irq_seq_pkg::*;
(
  input  logic       nmi_req,
  input  logic       irq_req,
  input  logic       swi_req,
  input  logic       iret_req,
  input  logic       ie_flag,
  output seq_event_t ev
);

  // Fixed priority: non-maskable, enabled maskable, trap, return.
  always_comb begin
    if (nmi_req)                 ev = EV_NMI;
    else if (irq_req && ie_flag) ev = EV_IRQ;
    else if (swi_req)            ev = EV_SWI;
    else if (iret_req)           ev = EV_RET;
    else                         ev = EV_NONE;
  end

endmodule

// File: rtl/irq_stack_ptr.sv
module irq_stack_ptr #(
  parameter int            AW      = 32,
  parameter int            STEP    = 4,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_dec
);

  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  assign sp_dec = sp - STEP_W;

  always_ff @(posedge clk) begin
    if (rst)       sp <= SP_INIT;
    else if (push) sp <= sp - STEP_W;
    else if (pop)  sp <= sp + STEP_W;
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  seq_event_t ev,
  output seq_state_t state
);

  seq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          unique case (ev)
            EV_NMI, EV_SWI: nxt = S_PUSH_F;
            EV_IRQ:         nxt = S_ACK;
            EV_RET:         nxt = S_POP_PC;
            default:        nxt = S_IDLE;
          endcase
        end
      end
      S_ACK:     nxt = S_PUSH_F;
      S_PUSH_F:  nxt = S_PUSH_PC;
      S_PUSH_PC: nxt = S_RD_VEC;
      S_RD_VEC:  nxt = S_WAIT_V;
      S_WAIT_V:  nxt = S_LOAD;
      S_POP_PC:  nxt = S_POP_F;
      S_POP_F:   nxt = S_WAIT_F;
      S_WAIT_F:  nxt = S_LOAD;
      S_LOAD:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int            AW      = 32,
  parameter int            FW      = 16,
  parameter int            IE_BIT  = 9,
  parameter logic [AW-1:0] SP_INIT = 32'h0000_0800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_done,
  input  logic [AW-1:0] pc_next,
  input  logic [FW-1:0] flags_in,
  input  logic          nmi_req,
  input  logic          irq_req,
  input  logic          swi_req,
  input  logic [7:0]    swi_vec,
  input  logic          iret_req,
  output logic          irq_ack,
  input  logic [7:0]    irq_vec_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          pc_load,
  output logic [AW-1:0] pc_out,
  output logic          flags_load,
  output logic [FW-1:0] flags_out,
  output logic [AW-1:0] sp_out
);

  localparam int            STEP    = AW / 8;
  localparam logic [FW-1:0] IE_MASK = FW'(1) << IE_BIT;

  seq_event_t    ev;
  seq_state_t    state;
  logic [AW-1:0] sp, sp_dec;
  logic          push, pop;
  logic [AW-1:0] ret_pc;
  logic [FW-1:0] sav_flags;
  logic [7:0]    vec;
  logic [AW-1:0] pc_q;
  logic [FW-1:0] flags_q;

  irq_event_arb u_arb (
    .nmi_req  (nmi_req),
    .irq_req  (irq_req),
    .swi_req  (swi_req),
    .iret_req (iret_req),
    .ie_flag  (flags_in[IE_BIT]),
    .ev       (ev)
  );

  irq_seq_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .start (instr_done),
    .ev    (ev),
    .state (state)
  );

  irq_stack_ptr #(
    .AW      (AW),
    .STEP    (STEP),
    .SP_INIT (SP_INIT)
  ) u_sp (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .pop    (pop),
    .sp     (sp),
    .sp_dec (sp_dec)
  );

  assign push = (state == S_PUSH_F) || (state == S_PUSH_PC);
  assign pop  = (state == S_POP_PC) || (state == S_POP_F);

  // Context capture and result registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_pc    <= '0;
      sav_flags <= '0;
      vec       <= '0;
      pc_q      <= '0;
      flags_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (instr_done && ev != EV_NONE) begin
            ret_pc    <= pc_next;
            sav_flags <= flags_in;
            vec       <= (ev == EV_NMI) ? NMI_VECTOR : swi_vec;
          end
        end
        S_ACK:    vec     <= irq_vec_in;
        S_WAIT_V: begin
          pc_q    <= mem_rdata;
          flags_q <= sav_flags & ~IE_MASK;
        end
        S_POP_F:  pc_q    <= mem_rdata;
        S_WAIT_F: flags_q <= mem_rdata[FW-1:0];
        default: ;
      endcase
    end
  end

  // Port decode from the state register.
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_F: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_dec;
        mem_wdata = AW'(sav_flags);
      end
      S_PUSH_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_dec;
        mem_wdata = ret_pc;
      end
      S_RD_VEC: begin
        mem_req  = 1'b1;
        mem_addr = AW'({vec, 2'b00});
      end
      S_POP_PC, S_POP_F: begin
        mem_req  = 1'b1;
        mem_addr = sp;
      end
      default: ;
    endcase
  end

  assign irq_ack    = (state == S_ACK);
  assign busy       = (state != S_IDLE);
  assign pc_load    = (state == S_LOAD);
  assign flags_load = (state == S_LOAD);
  assign pc_out     = pc_q;
  assign flags_out  = flags_q;
  assign sp_out     = sp;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_done,
  input logic          nmi_req,
  input logic          swi_req,
  input logic          iret_req,
  input logic          flags_ie,
  input logic          irq_ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic          busy,
  input logic          pc_load,
  input logic [AW-1:0] sp_out
);

  AST_IDLE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !instr_done) |=> !busy); // R1

  AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R1

  AST_PUSH_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |=> (sp_out == $past(sp_out) - AW'(4))); // R2

  AST_NMI_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (!busy && instr_done && nmi_req) |=> (busy && !irq_ack)); // R4

  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && instr_done && !nmi_req && !swi_req && !iret_req && !flags_ie) |=> !busy); // R5

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R7

  AST_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> busy); // R10

  AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !busy); // R10

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instr_done (instr_done),
  .nmi_req    (nmi_req),
  .swi_req    (swi_req),
  .iret_req   (iret_req),
  .flags_ie   (flags_in[IE_BIT]),
  .irq_ack    (irq_ack),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .busy       (busy),
  .pc_load    (pc_load),
  .sp_out     (sp_out)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

  localparam int          AW  = 32;
  localparam int          FW  = 16;
  localparam logic [31:0] SP0 = 32'h0000_0800;
  localparam logic [15:0] IEM = 16'h0200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_done = 1'b0;
  logic [AW-1:0] pc_next = '0;
  logic [FW-1:0] flags_in = '0;
  logic          nmi_req = 1'b0, irq_req = 1'b0, swi_req = 1'b0, iret_req = 1'b0;
  logic [7:0]    swi_vec = '0, irq_vec_in = '0;
  logic          irq_ack, mem_req, mem_we, busy, pc_load, flags_load;
  logic [AW-1:0] mem_addr, mem_wdata, mem_rdata, pc_out, sp_out;
  logic [FW-1:0] flags_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst(rst), .instr_done(instr_done), .pc_next(pc_next),
    .flags_in(flags_in), .nmi_req(nmi_req), .irq_req(irq_req),
    .swi_req(swi_req), .swi_vec(swi_vec), .iret_req(iret_req),
    .irq_ack(irq_ack), .irq_vec_in(irq_vec_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .pc_load(pc_load), .pc_out(pc_out),
    .flags_load(flags_load), .flags_out(flags_out), .sp_out(sp_out)
  );

  // Memory model: one-cycle read latency, byte addresses, word indexed.
  logic [31:0] mem [0:1023];
  logic [31:0] rd_q = '0;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_req && mem_we)  mem[mem_addr[11:2]] <= mem_wdata;
    if (mem_req && !mem_we) rd_q <= mem[mem_addr[11:2]];
  end

  function automatic logic [31:0] handler(input logic [7:0] v);
    return 32'h0000_1000 + {20'd0, v, 4'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one boundary and follow the sequence to its load cycle.
  task automatic strobe(input logic n, input logic i, input logic s, input logic r,
                        input logic [7:0] sv, input logic [7:0] cv,
                        input logic [15:0] fl, input logic [31:0] pcv,
                        output int lat, output logic ack_seen, output logic started);
    @(negedge clk);
    nmi_req = n; irq_req = i; swi_req = s; iret_req = r;
    swi_vec = sv; irq_vec_in = cv; flags_in = fl; pc_next = pcv;
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0; nmi_req = 1'b0; irq_req = 1'b0; swi_req = 1'b0; iret_req = 1'b0;
    ack_seen = irq_ack;
    started  = busy;
    lat = 0;
    if (started) begin
      lat = 1;
      while (!pc_load && lat < 20) begin
        @(negedge clk);
        ack_seen = ack_seen | irq_ack;
        lat++;
      end
    end
  endtask

  // Table: kind (0 non-maskable, 1 maskable, 2 trap), trap vector, controller vector, flags, pc
  localparam int NV = 7;
  localparam logic [1:0]  T_KIND [NV] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd0, 2'd2};
  localparam logic [7:0]  T_SV   [NV] = '{8'h00, 8'h00, 8'h21, 8'hFF, 8'h00, 8'h00, 8'h00};
  localparam logic [7:0]  T_CV   [NV] = '{8'h00, 8'h08, 8'h00, 8'h00, 8'h71, 8'h00, 8'h00};
  localparam logic [15:0] T_FL   [NV] = '{16'h02F3, 16'h0281, 16'h0045, 16'h0A00, 16'h0300, 16'h00C1, 16'h0201};
  localparam logic [31:0] T_PC   [NV] = '{32'h100, 32'h2468, 32'hABC0, 32'h7FFC, 32'h55A0, 32'h3330, 32'h4};

  task automatic do_return(input string req, input logic [31:0] pcv, input logic [15:0] fl);
    int lat; logic ack; logic st;
    strobe(0, 0, 0, 1, 8'h00, 8'h00, 16'h0000, 32'h0, lat, ack, st);
    check({req, " R9 return pc"}, pc_out, pcv);
    check({req, " R9 return flags"}, {16'd0, flags_out}, {16'd0, fl});
    check({req, " R9 flags_load"}, {31'd0, flags_load}, 32'd1);
    check({req, " R9 sp restored"}, sp_out, SP0);
    check({req, " R10 return latency"}, lat, 4);
  endtask

  initial begin
    int lat; logic ack; logic st; logic [7:0] ev;
    for (int k = 0; k < 1024; k++) mem[k] = (k < 256) ? handler(k[7:0]) : 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state
    @(negedge clk);
    check("R2 reset sp", sp_out, SP0);
    check("R10 reset busy", {31'd0, busy}, 32'd0);
    check("R1 reset mem_req", {31'd0, mem_req}, 32'd0);
    check("R3 reset pc_load", {31'd0, pc_load}, 32'd0);

    // Table walk
    for (int t = 0; t < NV; t++) begin
      ev = (T_KIND[t] == 2'd0) ? 8'd2 : (T_KIND[t] == 2'd1) ? T_CV[t] : T_SV[t];
      strobe(T_KIND[t] == 2'd0, T_KIND[t] == 2'd1, T_KIND[t] == 2'd2, 1'b0,
             T_SV[t], T_CV[t], T_FL[t], T_PC[t], lat, ack, st);
      check($sformatf("R3 handler t%0d", t), pc_out, handler(ev));
      check($sformatf("R4 R7 ack t%0d", t), {31'd0, ack}, {31'd0, T_KIND[t] == 2'd1});
      check($sformatf("R8 entry flags t%0d", t), {16'd0, flags_out}, {16'd0, T_FL[t] & ~IEM});
      check($sformatf("R2 pushed flags t%0d", t), mem[(SP0 - 4) >> 2], {16'd0, T_FL[t]});
      check($sformatf("R2 pushed pc t%0d", t), mem[(SP0 - 8) >> 2], T_PC[t]);
      check($sformatf("R2 sp after entry t%0d", t), sp_out, SP0 - 8);
      check($sformatf("R10 entry latency t%0d", t), lat, (T_KIND[t] == 2'd1) ? 6 : 5);
      do_return($sformatf("t%0d", t), T_PC[t], T_FL[t]);
    end

    // R1: requests without a strobe
    @(negedge clk);
    nmi_req = 1; irq_req = 1; swi_req = 1; flags_in = IEM;
    repeat (3) @(negedge clk);
    check("R1 no strobe busy", {31'd0, busy}, 32'd0);
    check("R1 no strobe sp", sp_out, SP0);
    nmi_req = 0; irq_req = 0; swi_req = 0;

    // R5: masked request
    strobe(0, 1, 0, 0, 8'h00, 8'h09, 16'h00FF, 32'h800, lat, ack, st);
    check("R5 masked busy", {31'd0, st}, 32'd0);
    check("R5 masked ack", {31'd0, ack}, 32'd0);
    check("R5 masked sp", sp_out, SP0);

    // R6: non-maskable beats maskable
    strobe(1, 1, 0, 0, 8'h00, 8'h0B, 16'h0200, 32'h900, lat, ack, st);
    check("R6 nmi over irq vector", pc_out, handler(8'd2));
    check("R6 nmi over irq ack", {31'd0, ack}, 32'd0);
    // R8: with IE cleared a maskable request is ignored while in the handler
    strobe(0, 1, 0, 0, 8'h00, 8'h0C, flags_out, 32'h1008, lat, ack, st);
    check("R8 nested irq blocked", {31'd0, st}, 32'd0);
    do_return("R6a", 32'h900, 16'h0200);

    // R6: maskable beats trap
    strobe(0, 1, 1, 0, 8'h40, 8'h0D, 16'h0200, 32'hA00, lat, ack, st);
    check("R6 irq over swi vector", pc_out, handler(8'h0D));
    check("R6 irq over swi ack", {31'd0, ack}, 32'd1);
    do_return("R6b", 32'hA00, 16'h0200);

    // R6: trap beats return; masked irq falls through to trap
    strobe(0, 1, 1, 1, 8'h33, 8'h0E, 16'h0000, 32'hB00, lat, ack, st);
    check("R6 swi over iret vector", pc_out, handler(8'h33));
    check("R6 swi over iret sp", sp_out, SP0 - 8);
    check("R7 swi no ack", {31'd0, ack}, 32'd0);
    do_return("R6c", 32'hB00, 16'h0000);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule